// File: doc/BRIEF.md
# IrDA Pulse Codec

This block sits between the serial bit stream of a UART and an infrared transceiver. On the transmit side, it turns every zero bit into a short high pulse and leaves every one bit dark. The pulse width comes from one of two sources. The first is a fraction of the bit time, three sixteen-times oversample ticks. The second is a fixed count of 2, 4, 8 and so on up to 256 clock cycles, chosen by a 3-bit code. On the receive side, each incoming pulse is stretched back into a full-length low bit that the UART receiver can sample.

The receive input can be inverted to suit the transceiver. The transmit output is never inverted. When the codec is disabled, both directions are plain wires. The UART framing itself is outside this block. The block is told where bits fall in two ways: through the sixteen-per-bit tick strobe, and through the edges of the transmit stream.

Top module: `irda_codec`

## Requirements
- R1: With `enable` low, `ir_tx` equals `uart_tx` and `uart_rx` equals the raw `ir_rx`. The `rx_invert` input has no effect in this state.
- R2: With `enable` high and no activity, `ir_tx` idles low while `uart_tx` is high, and `uart_rx` idles high.
- R3: With `enable` high and `fixed_pulse` low, a bit start raises `ir_tx` from the clock edge that detects it. The pulse lasts until the third later `tick16` edge. A bit start is either a falling edge of `uart_tx`, or the sixteenth tick since the previous bit start while `uart_tx` stays low. With ticks every D clocks and a start coinciding with a tick edge, the pulse is 3·D cycles long.
- R4: With `fixed_pulse` high, a bit start produces a high pulse of exactly 2^(n+1) clock cycles, where n is the 3-bit `pulse_code`. Code 0 gives 2 cycles and code 7 gives 256 cycles.
- R5: One bits produce no pulse. A transmitted character produces exactly one pulse per zero bit, including the start bit, and none for data ones or stop bits.
- R6: The receive input is XORed with `rx_invert` and passed through a two-flop synchroniser. A rising edge of the synchronised value drives `uart_rx` low from the third clock edge after the input turns active. `uart_rx` stays low until the sixteenth `tick16` edge counted after that point.
- R7: A new receive pulse that arrives while `uart_rx` is already low restarts the sixteen-tick count, so the low period extends without a high gap.
- R8: `rx_invert` acts on the receive input only. A character encoded with `rx_invert` high gives the same `ir_tx` pulses as with it low. With `rx_invert` high, an active-low pulse on `ir_rx` decodes the same way an active-high pulse does without it.
- R9: After a synchronous active-low reset with `enable` high, `ir_tx` reads 0 and `uart_rx` reads 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | 1 = infrared coding, 0 = pass-through |
| rx_invert | input | 1 | Invert the receive input before decoding |
| fixed_pulse | input | 1 | 1 = clock-count pulse width, 0 = three-tick width |
| pulse_code | input | 3 | Fixed width code n, width 2^(n+1) clocks |
| tick16 | input | 1 | One-cycle strobe, sixteen per bit time |
| uart_tx | input | 1 | Serial data from the UART transmitter |
| ir_tx | output | 1 | Pulse output to the infrared transmitter |
| ir_rx | input | 1 | Pulse input from the infrared receiver |
| uart_rx | output | 1 | Reconstructed serial data to the UART receiver |

## Verification
The transmit pulse starts on the first clock edge that sees the bit start, so it is visible one cycle after the stimulus. The stretched receive low begins on the third edge after the input turns active, because two synchroniser flops and one edge register lie in between. The bench drives every stimulus on a clock cycle whose following edge carries a tick, and counts output cycles over whole bit windows. Expected counts are derived from the tick period D: 3·D for a three-tick pulse, 2^(n+1) for a fixed pulse, and the receive low length from the first counted tick after the third edge plus fifteen more periods. The sweeps cover tick periods of 1 and 4 clocks.

// File: rtl/irda_pkg.sv
// Shared definitions for the infrared pulse codec.
// Assumes the fixed-width code is narrow enough that 2^(2^CODE_W) fits a counter.
package irda_pkg;
    localparam int CODE_W = 3;
    localparam int FIX_W  = 1 << CODE_W;   // counter bits for the longest fixed pulse

    typedef enum logic {
        MODE_FRAC  = 1'b0,                 // width counted in oversample ticks
        MODE_FIXED = 1'b1                  // width counted in clock cycles
    } pulse_mode_e;

    // Last count value of a fixed pulse: 2^(code+1) - 1
    function automatic logic [FIX_W-1:0] fixed_limit(input logic [CODE_W-1:0] code);
        logic [FIX_W:0] full;
        full = (FIX_W+1)'(2) << code;
        return FIX_W'(full - (FIX_W+1)'(1));
    endfunction
endpackage

// File: rtl/irda_sync.sv
// Multi-flop synchroniser for one asynchronous bit.
// Assumes STAGES >= 2; resets to zero (the idle level after polarity correction).
module irda_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the input through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/irda_encoder.sv
// Transmit side: turns each zero bit into one high pulse.
// Assumes tick16 strobes TICKS_PER_BIT times per bit and bit_in changes only at bit boundaries.
module irda_encoder
    import irda_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16,
    parameter int PULSE_TICKS   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  pulse_mode_e       mode,
    input  logic [CODE_W-1:0] code,
    input  logic              tick16,
    input  logic              bit_in,
    output logic              pulse_out
);
    localparam int PH_W = $clog2(TICKS_PER_BIT);
    localparam int PT_W = $clog2(PULSE_TICKS + 1);

    logic              prev_bit;
    logic              fall;
    logic [PH_W-1:0]   phase;
    logic              bit_start;
    logic              pulse_q;
    logic [PT_W-1:0]   tick_cnt;
    logic [FIX_W-1:0]  clk_cnt;
    logic [FIX_W-1:0]  lim;

    assign fall      = prev_bit & ~bit_in;
    assign bit_start = en & (fall | (tick16 & (phase == PH_W'(TICKS_PER_BIT - 1)) & ~bit_in));
    assign lim       = fixed_limit(code);

    // Remember the previous stream level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_bit <= 1'b1;
        else        prev_bit <= bit_in;
    end

    // Track the tick position inside the current bit, resynchronised on falling edges
    always_ff @(posedge clk) begin
        if (!rst_n || !en) phase <= '0;
        else if (fall)     phase <= '0;
        else if (tick16)   phase <= phase + PH_W'(1);
    end

    // Pulse generator: start on a bit start, stop after the selected width
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            pulse_q  <= 1'b0;
            tick_cnt <= '0;
            clk_cnt  <= '0;
        end else if (bit_start) begin
            pulse_q  <= 1'b1;
            tick_cnt <= '0;
            clk_cnt  <= '0;
        end else if (pulse_q) begin
            if (mode == MODE_FRAC) begin
                if (tick16) begin
                    if (tick_cnt == PT_W'(PULSE_TICKS - 1)) pulse_q  <= 1'b0;
                    else                                    tick_cnt <= tick_cnt + PT_W'(1);
                end
            end else begin
                if (clk_cnt == lim) pulse_q <= 1'b0;
                else                clk_cnt <= clk_cnt + FIX_W'(1);
            end
        end
    end

    assign pulse_out = pulse_q;

    // A pulse only ever begins from a detected bit start
    assert_pulse_from_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_q) |-> $past(bit_start));

    // A three-tick pulse ends only on a tick edge
    assert_frac_end_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pulse_q) && $past(en) && $past(mode == MODE_FRAC)) |-> $past(tick16));

    // A fixed pulse never counts past its limit
    assert_no_overrun_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_q && mode == MODE_FIXED) |-> (clk_cnt <= lim));
endmodule

// File: rtl/irda_decoder.sv
// Receive side: stretches each received pulse into one full low bit.
// Assumes tick16 strobes TICKS_PER_BIT times per bit; the input is asynchronous.
module irda_decoder #(
    parameter int TICKS_PER_BIT = 16,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic invert,
    input  logic tick16,
    input  logic ir_in,
    output logic bit_out
);
    localparam int TC_W = $clog2(TICKS_PER_BIT);

    logic            rx_in;
    logic            rx_sync;
    logic            rx_prev;
    logic            rise;
    logic            busy;
    logic [TC_W-1:0] tcnt;

    assign rx_in = ir_in ^ invert;

    irda_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rx_in),
        .q     (rx_sync)
    );

    assign rise = rx_sync & ~rx_prev;

    // Delay the synchronised level by one cycle for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) rx_prev <= 1'b0;
        else        rx_prev <= rx_sync;
    end

    // Hold the output low for one bit time, restarting on each new pulse
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            busy <= 1'b0;
            tcnt <= '0;
        end else if (rise) begin
            busy <= 1'b1;
            tcnt <= '0;
        end else if (busy && tick16) begin
            if (tcnt == TC_W'(TICKS_PER_BIT - 1)) busy <= 1'b0;
            else                                  tcnt <= tcnt + TC_W'(1);
        end
    end

    assign bit_out = ~busy;

    // The stretch starts only from a synchronised rising edge
    assert_stretch_from_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(rise));

    // The stretch releases only on a tick edge
    assert_release_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(en)) |-> $past(tick16));
endmodule

// File: rtl/irda_codec.sv
// Infrared pulse codec top: encoder and decoder, bypassed when disabled.
// Assumes tick16 is a single-cycle strobe at sixteen times the bit rate.
module irda_codec
    import irda_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16,
    parameter int PULSE_TICKS   = 3,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              rx_invert,
    input  logic              fixed_pulse,
    input  logic [CODE_W-1:0] pulse_code,
    input  logic              tick16,
    input  logic              uart_tx,
    output logic              ir_tx,
    input  logic              ir_rx,
    output logic              uart_rx
);
    pulse_mode_e mode;
    logic        enc_pulse;
    logic        dec_bit;

    assign mode = fixed_pulse ? MODE_FIXED : MODE_FRAC;

    irda_encoder #(.TICKS_PER_BIT(TICKS_PER_BIT), .PULSE_TICKS(PULSE_TICKS)) u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (enable),
        .mode      (mode),
        .code      (pulse_code),
        .tick16    (tick16),
        .bit_in    (uart_tx),
        .pulse_out (enc_pulse)
    );

    irda_decoder #(.TICKS_PER_BIT(TICKS_PER_BIT), .SYNC_STAGES(SYNC_STAGES)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (enable),
        .invert  (rx_invert),
        .tick16  (tick16),
        .ir_in   (ir_rx),
        .bit_out (dec_bit)
    );

    // Output selection: coded paths when enabled, straight wires otherwise
    assign ir_tx   = enable ? enc_pulse : uart_tx;
    assign uart_rx = enable ? dec_bit   : ir_rx;

    // A rising output pulse while coding is always preceded by a low stream bit
    assert_one_is_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && $rose(ir_tx)) |-> !$past(uart_tx));
endmodule

// File: tb/tb_irda_codec.sv
module tb_irda_codec;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b1;
    logic       rx_invert = 1'b0;
    logic       fixed_pulse = 1'b0;
    logic [2:0] pulse_code = 3'd0;
    logic       tick16 = 1'b0;
    logic       uart_tx = 1'b1;
    logic       ir_tx;
    logic       ir_rx = 1'b0;
    logic       uart_rx;

    int   checks = 0;
    int   errors = 0;
    int   tick_div = 4;
    int   tdiv_cnt = 0;
    logic enc_last = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irda_codec dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .rx_invert   (rx_invert),
        .fixed_pulse (fixed_pulse),
        .pulse_code  (pulse_code),
        .tick16      (tick16),
        .uart_tx     (uart_tx),
        .ir_tx       (ir_tx),
        .ir_rx       (ir_rx),
        .uart_rx     (uart_rx)
    );

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #(CLK_PERIOD * WD_CYCLES);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One cycle: move to the falling edge and update the tick strobe
    task automatic step();
        @(negedge clk);
        tdiv_cnt = (tdiv_cnt + 1) % tick_div;
        tick16   = (tdiv_cnt == 0);
    endtask

    task automatic to_tick();
        do step(); while (!tick16);
    endtask

    // Drive one bit for sixteen ticks, counting high cycles and rising edges on ir_tx
    task automatic run_bit(input logic b, output int hi, output int rises);
        uart_tx = b;
        hi = 0;
        rises = 0;
        for (int k = 0; k < 16 * tick_div; k++) begin
            step();
            if (ir_tx) hi++;
            if (ir_tx && !enc_last) rises++;
            enc_last = ir_tx;
        end
    endtask

    // Send start, eight data bits LSB first, stop, and one idle bit
    task automatic send_frame(input logic [7:0] v, input string tag);
        logic [10:0] bits;
        int hi, rises, tot_r, zeros;
        bits  = {1'b1, 1'b1, v, 1'b0};
        tot_r = 0;
        zeros = 0;
        to_tick();
        enc_last = ir_tx;
        for (int i = 0; i < 11; i++) begin
            run_bit(bits[i], hi, rises);
            chk($sformatf("R3 %s bit %0d high cycles", tag, i), hi, bits[i] ? 0 : 3 * tick_div);
            tot_r += rises;
            if (!bits[i]) zeros++;
        end
        uart_tx = 1'b1;
        chk($sformatf("R5 %s pulses per frame", tag), tot_r, zeros);
    endtask

    function automatic int first_tick_index(input int d);
        int m;
        m = 0;
        while (1 + m * d <= 3) m++;
        return m;
    endfunction

    // One or two receive pulses of width w; gap > 0 adds a second pulse gap cycles later
    task automatic rx_case(input int w, input int gap, input string tag);
        logic act, idle, last;
        int lows, falls, expv;
        act   = ~rx_invert;
        idle  = rx_invert;
        lows  = 0;
        falls = 0;
        last  = 1'b1;
        expv  = gap + (first_tick_index(tick_div) + 15) * tick_div - 2;
        to_tick();
        ir_rx = act;
        for (int k = 1; k <= 40 * tick_div + 20; k++) begin
            step();
            if (!uart_rx) lows++;
            if (!uart_rx && last) falls++;
            last = uart_rx;
            if (k == w) ir_rx = idle;
            if (gap > 0 && k == gap) ir_rx = act;
            if (gap > 0 && k == gap + w) ir_rx = idle;
        end
        chk($sformatf("%s low cycles", tag), lows, expv);
        chk($sformatf("%s low periods", tag), falls, 1);
    endtask

    initial begin
        logic [7:0] pats [8] = '{8'h00, 8'hFF, 8'h55, 8'hAA, 8'h0F, 8'hF0, 8'h81, 8'h3C};
        int hi, rises, mism;

        // Reset state
        repeat (5) step();
        rst_n = 1'b1;
        repeat (3) step();
        chk("R9 reset ir_tx", ir_tx, 0);
        chk("R9 reset uart_rx", uart_rx, 1);

        // Idle while enabled
        repeat (40) step();
        chk("R2 idle ir_tx low", ir_tx, 0);
        chk("R2 idle uart_rx high", uart_rx, 1);

        // Three-tick pulses over two tick periods and several characters
        foreach (tick_div_list[j]) begin
            tick_div = tick_div_list[j];
            tdiv_cnt = 0;
            foreach (pats[p]) send_frame(pats[p], $sformatf("D%0d pat%0h", tick_div, pats[p]));
        end

        // Fixed-width sweep over every code
        tick_div = 4;
        tdiv_cnt = 0;
        fixed_pulse = 1'b1;
        for (int n = 0; n < 8; n++) begin
            pulse_code = 3'(n);
            to_tick();
            uart_tx = 1'b0;
            hi = 0;
            rises = 0;
            enc_last = ir_tx;
            for (int k = 1; k <= 300; k++) begin
                step();
                if (ir_tx) hi++;
                if (ir_tx && !enc_last) rises++;
                enc_last = ir_tx;
                if (k == 16 * tick_div) uart_tx = 1'b1;
            end
            chk($sformatf("R4 code %0d width", n), hi, 2 << n);
            chk($sformatf("R4 code %0d pulses", n), rises, 1);
        end
        fixed_pulse = 1'b0;

        // Receive stretching, single and restarted, both tick periods
        foreach (tick_div_list[j]) begin
            tick_div = tick_div_list[j];
            tdiv_cnt = 0;
            for (int w = 1; w <= 3; w++)
                rx_case(w, 0, $sformatf("R6 D%0d w%0d", tick_div, w));
            rx_case(2, 8 * tick_div, $sformatf("R7 D%0d restart", tick_div));
        end

        // Inverted input: receive polarity flips, transmit unchanged
        tick_div = 4;
        tdiv_cnt = 0;
        rx_invert = 1'b1;
        ir_rx = 1'b1;
        repeat (10) step();
        chk("R8 inverted idle uart_rx", uart_rx, 1);
        rx_case(2, 0, "R8 inverted rx pulse");
        send_frame(8'h5A, "R8 inverted tx");

        // Pass-through when disabled; inversion ignored
        enable = 1'b0;
        mism = 0;
        for (int k = 0; k < 8; k++) begin
            uart_tx = k[0];
            ir_rx = k[1];
            step();
            if (ir_tx !== uart_tx) mism++;
            if (uart_rx !== ir_rx) mism++;
        end
        chk("R1 pass-through mismatches", mism, 0);
        uart_tx = 1'b0;
        ir_rx = 1'b0;
        mism = 0;
        for (int k = 0; k < 100; k++) begin
            step();
            if (ir_tx !== 1'b0 || uart_rx !== 1'b0) mism++;
        end
        chk("R1 held low passes straight", mism, 0);
        uart_tx = 1'b1;
        ir_rx = 1'b1;
        step();
        chk("R1 ir_tx follows high", ir_tx, 1);
        chk("R1 uart_rx raw despite invert", uart_rx, 1);

        // Re-enable with quiet lines
        repeat (10) step();
        enable = 1'b1;
        repeat (5) step();
        chk("R2 re-enabled ir_tx low", ir_tx, 0);
        chk("R2 re-enabled uart_rx high", uart_rx, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    int tick_div_list [2] = '{1, 4};
endmodule